// File: doc/BRIEF.md
# Power-Gated Retention Register with Output Clamp

This block models one register inside a switchable power domain. The register has a shadow copy that keeps its value while the domain is off. Its output to the always-on side passes through a clamp. The model is meant to sit under a power sequencer as the device being controlled. It makes every ordering mistake the sequencer can make visible at its ports.

When the domain's supply enable is low, the working register is overwritten every cycle with a corruption fill value. By default that value is all unknown. An active-low save copies the working value into the shadow, and an active-low restore copies the shadow back. While isolation is asserted, the always-on side sees a fixed clamp value instead of the register.

Four sticky flags record the ordering mistakes:
- power was cut with the clamp open;
- power was cut while the register held an unsaved write;
- a restore was attempted with the domain unpowered;
- the clamp was opened while a restore was still owed.

The always-on output and the flags are registered, so each reflects the inputs sampled at the previous rising edge.

Top module: `retained_clamp_reg`

## Requirements
- R1: In every cycle that `pwr_on` is sampled low, the working register is loaded with `CORRUPT_FILL`. With isolation off, `aon_data` shows that value after the same edge.
- R2: A write (`wr_en`=1) is taken only when `pwr_on`=1 and `restore_n`=1. It is ignored while unpowered or while a restore is active, and it never touches the shadow.
- R3: A save (`save_n`=0) with `pwr_on`=1 copies the working value present before the edge into the shadow. The shadow then holds that value through power-off and through later writes.
- R4: A save with `pwr_on`=0 loads `CORRUPT_FILL` into the shadow, so the retained state is lost.
- R5: A restore (`restore_n`=0) with `pwr_on`=1 loads the shadow into the working register and takes priority over a write in the same cycle.
- R6: A restore with `pwr_on`=0 leaves the register corrupted and sets `err_dead_restore`.
- R7: While `iso_on`=1 is sampled, `aon_data` equals `CLAMP_VAL` (default all zeros) after the edge. Otherwise `aon_data` equals the working register's new value.
- R8: `err_leak` is set when `pwr_on` is sampled low after being sampled high at the previous edge, and `iso_on` is low at that edge.
- R9: `err_nosave` is set when power falls (as in R8) and a write has been taken since the last powered save or since reset.
- R10: A restore becomes owed when power falls and stays owed until a powered restore. `err_early_release` is set when `iso_on` falls while a restore is owed, unless a powered restore happens in that same cycle.
- R11: Synchronous active-high `rst` gives `aon_data`=`CLAMP_VAL`, a zero working register, a zero shadow, no owed restore and all flags clear. Each flag stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on | input | 1 | Domain supply enable, 1 = powered |
| save_n | input | 1 | Copy working register to shadow, active low |
| restore_n | input | 1 | Copy shadow to working register, active low |
| iso_on | input | 1 | Clamp the always-on output, active high |
| wr_en | input | 1 | Functional write enable |
| wr_data | input | DATA_W | Functional write data |
| aon_data | output | DATA_W | Registered, clamped value seen by the always-on domain |
| err_leak | output | 1 | Sticky: power cut with clamp open |
| err_nosave | output | 1 | Sticky: power cut with an unsaved write |
| err_dead_restore | output | 1 | Sticky: restore while unpowered |
| err_early_release | output | 1 | Sticky: clamp opened while a restore is owed |

## Verification
The bench builds the block with `DATA_W`=8, `CLAMP_VAL`=8'h3C and `CORRUPT_FILL`=8'hA5. These are non-zero patterns, distinct from each other and from the write data, so a clamped output, a corrupted register and a zero reset value can each be told apart in two-state simulation. With these values a lost shadow shows up as A5 after a restore, and an early clamp release shows A5 where a restored value was due. A vector table walks a full correct power cycle and then a sequence of stacked violations. Directed runs then isolate each flag on its own and check that reset clears them.

// File: rtl/retclamp_pkg.sv
package retclamp_pkg;
  typedef struct packed {
    logic leak;
    logic nosave;
    logic dead_restore;
    logic early_release;
  } seq_err_t;
endpackage

// File: rtl/retain_store.sv
module retain_store #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CORRUPT_FILL = 'x
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              save_n,
  input  logic              restore_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] main_d,
  output logic              wr_accept
);
  logic [DATA_W-1:0] main_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] shadow_d;

  always_comb begin
    wr_accept = pwr_on && restore_n && wr_en;
    if (!pwr_on)
      main_d = CORRUPT_FILL;
    else if (!restore_n)
      main_d = shadow_q;
    else if (wr_en)
      main_d = wr_data;
    else
      main_d = main_q;

    if (!save_n)
      shadow_d = pwr_on ? main_q : CORRUPT_FILL;
    else
      shadow_d = shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q   <= '0;
      shadow_q <= '0;
    end else begin
      main_q   <= main_d;
      shadow_q <= shadow_d;
    end
  end
endmodule

// File: rtl/seq_monitor.sv
module seq_monitor
  import retclamp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pwr_on,
  input  logic     save_n,
  input  logic     restore_n,
  input  logic     iso_on,
  input  logic     wr_accept,
  output seq_err_t err_q
);
  logic     pwr_q, iso_q, dirty_q, owed_q;
  logic     pwr_fall, iso_rel, live_restore, owed_now;
  seq_err_t err_d;

  always_comb begin
    pwr_fall     = pwr_q && !pwr_on;
    iso_rel      = iso_q && !iso_on;
    live_restore = pwr_on && !restore_n;
    owed_now     = (owed_q || pwr_fall) && !live_restore;

    err_d.leak          = err_q.leak          || (pwr_fall && !iso_on);
    err_d.nosave        = err_q.nosave        || (pwr_fall && dirty_q);
    err_d.dead_restore  = err_q.dead_restore  || (!pwr_on && !restore_n);
    err_d.early_release = err_q.early_release || (iso_rel && owed_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q   <= 1'b1;
      iso_q   <= 1'b1;
      dirty_q <= 1'b0;
      owed_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      pwr_q   <= pwr_on;
      iso_q   <= iso_on;
      dirty_q <= wr_accept || (dirty_q && !(pwr_on && !save_n));
      if (live_restore)
        owed_q <= 1'b0;
      else if (pwr_fall)
        owed_q <= 1'b1;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/iso_stage.sv
module iso_stage #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CLAMP_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iso_on,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] aon_q
);
  always_ff @(posedge clk) begin
    if (rst)
      aon_q <= CLAMP_VAL;
    else
      aon_q <= iso_on ? CLAMP_VAL : data_in;
  end
endmodule

// File: rtl/retained_clamp_reg.sv
module retained_clamp_reg
  import retclamp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CLAMP_VAL = '0,
  parameter logic [DATA_W-1:0] CORRUPT_FILL = 'x
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              save_n,
  input  logic              restore_n,
  input  logic              iso_on,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] aon_data,
  output logic              err_leak,
  output logic              err_nosave,
  output logic              err_dead_restore,
  output logic              err_early_release
);
  logic [DATA_W-1:0] main_d;
  logic              wr_accept;
  seq_err_t          err_q;

  retain_store #(.DATA_W(DATA_W), .CORRUPT_FILL(CORRUPT_FILL)) u_store (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .save_n(save_n),
    .restore_n(restore_n), .wr_en(wr_en), .wr_data(wr_data),
    .main_d(main_d), .wr_accept(wr_accept)
  );

  seq_monitor u_mon (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .save_n(save_n),
    .restore_n(restore_n), .iso_on(iso_on), .wr_accept(wr_accept),
    .err_q(err_q)
  );

  iso_stage #(.DATA_W(DATA_W), .CLAMP_VAL(CLAMP_VAL)) u_iso (
    .clk(clk), .rst(rst), .iso_on(iso_on), .data_in(main_d), .aon_q(aon_data)
  );

  assign err_leak          = err_q.leak;
  assign err_nosave        = err_q.nosave;
  assign err_dead_restore  = err_q.dead_restore;
  assign err_early_release = err_q.early_release;
endmodule

// File: rtl/retained_clamp_reg_chk.sv
module retained_clamp_reg_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CLAMP_VAL = '0,
  parameter logic [DATA_W-1:0] CORRUPT_FILL = 'x
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_on,
  input logic              restore_n,
  input logic              iso_on,
  input logic [DATA_W-1:0] aon_data,
  input logic              err_leak,
  input logic              err_nosave,
  input logic              err_dead_restore,
  input logic              err_early_release
);
  AST_CORRUPT_SEEN: assert property (@(posedge clk) disable iff (rst)
    (!pwr_on && !iso_on) |=> (aon_data === CORRUPT_FILL)); // R1
  AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    iso_on |=> (aon_data === CLAMP_VAL)); // R7
  AST_DEAD_RESTORE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!pwr_on && !restore_n) |=> err_dead_restore); // R6
  AST_LEAK_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwr_on) && !iso_on) |=> err_leak); // R8
  AST_STICKY_LEAK: assert property (@(posedge clk) disable iff (rst)
    err_leak |=> err_leak); // R11
  AST_STICKY_NOSAVE: assert property (@(posedge clk) disable iff (rst)
    err_nosave |=> err_nosave); // R11
  AST_STICKY_DEAD: assert property (@(posedge clk) disable iff (rst)
    err_dead_restore |=> err_dead_restore); // R11
  AST_STICKY_EARLY: assert property (@(posedge clk) disable iff (rst)
    err_early_release |=> err_early_release); // R11
endmodule

bind retained_clamp_reg retained_clamp_reg_chk #(
  .DATA_W(DATA_W), .CLAMP_VAL(CLAMP_VAL), .CORRUPT_FILL(CORRUPT_FILL)
) u_chk (
  .clk(clk), .rst(rst), .pwr_on(pwr_on), .restore_n(restore_n),
  .iso_on(iso_on), .aon_data(aon_data), .err_leak(err_leak),
  .err_nosave(err_nosave), .err_dead_restore(err_dead_restore),
  .err_early_release(err_early_release)
);

// File: tb/retained_clamp_reg_test.sv
`timescale 1ns/1ps
module retained_clamp_reg_test;
  localparam int W = 8;
  localparam logic [W-1:0] CLAMP = 8'h3C;
  localparam logic [W-1:0] FILL  = 8'hA5;
  localparam int NV = 16;

  // {pwr, save_n, restore_n, iso, wr_en} data expected_aon {leak,nosave,dead,early}
  localparam logic [24:0] VEC [NV] = '{
    {5'b11101, 8'h11, 8'h11, 4'b0000},
    {5'b11101, 8'h22, 8'h22, 4'b0000},
    {5'b11110, 8'h00, 8'h3C, 4'b0000},
    {5'b10110, 8'h00, 8'h3C, 4'b0000},
    {5'b01110, 8'h00, 8'h3C, 4'b0000},
    {5'b01111, 8'h77, 8'h3C, 4'b0000},
    {5'b11110, 8'h00, 8'h3C, 4'b0000},
    {5'b11010, 8'h00, 8'h3C, 4'b0000},
    {5'b11100, 8'h00, 8'h22, 4'b0000},
    {5'b11101, 8'h5A, 8'h5A, 4'b0000},
    {5'b01100, 8'h00, 8'hA5, 4'b1100},
    {5'b01000, 8'h00, 8'hA5, 4'b1110},
    {5'b00110, 8'h00, 8'h3C, 4'b1110},
    {5'b11110, 8'h00, 8'h3C, 4'b1110},
    {5'b11011, 8'h99, 8'h3C, 4'b1110},
    {5'b11100, 8'h00, 8'hA5, 4'b1110}
  };

  logic clk = 1'b0;
  logic rst, pwr_on, save_n, restore_n, iso_on, wr_en;
  logic [W-1:0] wr_data, aon_data;
  logic err_leak, err_nosave, err_dead_restore, err_early_release;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  retained_clamp_reg #(.DATA_W(W), .CLAMP_VAL(CLAMP), .CORRUPT_FILL(FILL)) uut (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .save_n(save_n),
    .restore_n(restore_n), .iso_on(iso_on), .wr_en(wr_en), .wr_data(wr_data),
    .aon_data(aon_data), .err_leak(err_leak), .err_nosave(err_nosave),
    .err_dead_restore(err_dead_restore), .err_early_release(err_early_release)
  );

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 9: return "R2 write";
      2: return "R7 clamp";
      3, 4, 5, 6: return "R3 save/hold";
      7, 8: return "R5 restore";
      10: return "R1 R8 R9 off unclamped";
      11: return "R6 dead restore";
      12: return "R4 save unpowered";
      13, 14: return "R5 restore wins over write";
      default: return "R4 lost state";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {err_leak, err_nosave, err_dead_restore, err_early_release};
  endfunction

  task automatic step(logic p, logic s, logic r, logic i, logic w, logic [W-1:0] d);
    pwr_on = p; save_n = s; restore_n = r; iso_on = i; wr_en = w; wr_data = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pwr_on = 1'b1; save_n = 1'b1; restore_n = 1'b1; iso_on = 1'b1;
    wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R11 reset aon", aon_data, CLAMP);
    check("R11 reset flags", {4'b0, flags()}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
      check(vec_tag(i), aon_data, VEC[i][11:4]);
      check({vec_tag(i), " flags"}, {4'b0, flags()}, {4'b0, VEC[i][3:0]});
    end

    // R11: reset clears sticky flags and zeroes the working register
    do_reset();
    check("R11 flags cleared", {4'b0, flags()}, 8'h00);
    step(1, 1, 1, 0, 0, 8'h00);
    check("R11 register zero after reset", aon_data, 8'h00);

    // R8 alone: power cut with clamp open, no write pending
    step(0, 1, 1, 0, 0, 8'h00);
    check("R8 leak flag only", {4'b0, flags()}, 8'h08);
    check("R1 corrupt visible", aon_data, FILL);

    // R9 alone: unsaved write then isolated power cut
    do_reset();
    step(1, 1, 1, 1, 1, 8'h10);
    step(0, 1, 1, 1, 0, 8'h00);
    check("R9 nosave flag only", {4'b0, flags()}, 8'h04);
    check("R7 clamp while off", aon_data, CLAMP);

    // R10: clamp opened after power-up without restore
    do_reset();
    step(1, 1, 1, 1, 1, 8'h44);
    step(1, 0, 1, 1, 0, 8'h00);
    step(0, 1, 1, 1, 0, 8'h00);
    step(1, 1, 1, 1, 0, 8'h00);
    check("R10 no flag before release", {4'b0, flags()}, 8'h00);
    step(1, 1, 1, 0, 0, 8'h00);
    check("R10 early release flag", {4'b0, flags()}, 8'h01);
    check("R10 unrestored value leaks", aon_data, FILL);
    step(1, 0, 1, 0, 0, 8'h00);
    step(1, 1, 0, 0, 0, 8'h00);
    check("R5 R10 late restore gets corrupt save", aon_data, FILL);
    check("R11 early flag sticky", {4'b0, flags()}, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule